// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked single-port memory model with separate write and read data buses. Every address, chip enable, burst control and write enable is captured on the rising clock edge. An access is opened by one of two address strobes. The controller-side strobe always takes the presented address. The processor-side strobe is honoured only while the chip enable is asserted. After the opening edge, the two low address bits come from an internal 2-bit burst counter. This counter steps on each edge that samples the advance input low. The `mode` pin is read without a clock. It selects wrap-around linear order or XOR-based interleaved order.

Each cycle in which the chip is selected is an access. If any lane write enable is active, the access is a write. Otherwise it is a read. Data is arranged in 9-bit byte lanes, each holding 8 data bits and 1 parity bit. Read data passes through an array register and an output register. The output drivers are gated by an asynchronous output enable. When the drivers are off, the data bus reads as zero. A sleep input suppresses every access while leaving the address and burst state untouched.

Top module: `burst_sram`

## Requirements
- R1: When `adsc_n` is low at an edge, the block loads `addr`, clears the burst counter and takes the chip-selected state from `ce_n`, regardless of `adsp_n`. A load with `ce_n` high deselects the chip.
- R2: When `adsp_n` is low and `adsc_n` is high at an edge, the block loads only if `ce_n` is low. With `ce_n` high the strobe is ignored, and a running burst continues at its next address.
- R3: While selected, an edge with `adv_n` low and no load steps the burst counter by one. With `adv_n` high and no load, the counter holds and the same word is accessed again.
- R4: With `mode` = 0 (linear), the low two address bits are (start + count) mod 4, and the upper bits stay fixed.
- R5: With `mode` = 1 (interleaved), the low two address bits are start XOR count.
- R6: A read access at edge N appears on `dout` after edge N+1. With a load at edge L and `adv_n` low on the following three edges, the four words appear after edges L+2 to L+5.
- R7: Lane i (bits 9i+8..9i) is written when `bwe_n` and `bw_n[i]` are both low. If no lane is enabled, the access is a read. This includes the case where `bw_n` is low but `bwe_n` is high.
- R8: When `gw_n` is low, all lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R9: `dout_drv` is high only in the cycle that follows the output-register update of a read. After an edge that deselects the chip, the drivers can stay on through the next cycle only, and are off after the second edge.
- R10: When `oe_n` is high, `dout_drv` is low, without waiting for a clock edge. Whenever `dout_drv` is low, `dout` is zero.
- R11: While `sleep` is high at an edge, no write and no read takes place at that edge.
- R12: During and directly after reset, the chip is deselected and `dout_drv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| ce_n | input | 1 | Chip enable, sampled on loads, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write for all lanes, active low |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| din | input | 9*LANES | Write data, 9 bits per lane |
| sleep | input | 1 | Suppresses accesses while high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 9*LANES | Read data, zero when not driven |
| dout_drv | output | 1 | High while the output drivers are on |

## Verification
On every cycle, the assertions check four things. The output enable must gate the drivers, and an undriven bus must read as zero. Strobe loads must set the counter and the select state correctly, and an ignored processor strobe must leave the select state alone. The counter must step or hold as the advance input directs. The drivers must be off two edges after sleep and three edges after a deselect.

The data values are left to the bench scenarios. These cover the linear and interleaved address sequences, stalled bursts, and lane merging under byte writes. They also confirm that a no-lane write becomes a read, and that an ignored strobe lets a burst continue. Writes suppressed by sleep must leave the array contents as they were. The bench also checks the exact output cycle of every read word against its access edge.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 adsc_n,
  input  logic                 adsp_n,
  input  logic                 ce_n,
  input  logic                 adv_n,
  input  logic                 mode,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic [9*LANES-1:0]   din,
  input  logic                 sleep,
  input  logic                 oe_n,
  output logic [9*LANES-1:0]   dout,
  output logic                 dout_drv
);
  localparam int LW    = 9;
  localparam int DW    = LW * LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic              act;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [DW-1:0]     mem [DEPTH];
  logic              rd1_vld, oq_vld;
  logic [DW-1:0]     rd1_q, oq;
  logic [1:0]        off;
  logic [ADDR_W-1:0] cur;
  logic [LANES-1:0]  lane_we;
  logic              load, go, do_rd;

  assign load    = !adsc_n || (!adsp_n && !ce_n);
  assign off     = mode ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
  assign cur     = {base[ADDR_W-1:2], off};
  assign lane_we = {LANES{!gw_n}} | ({LANES{!bwe_n}} & ~bw_n);
  assign go      = act && !sleep;
  assign do_rd   = go && (lane_we == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd1_vld <= 1'b0;
      oq_vld  <= 1'b0;
    end else begin
      if (load) begin
        act  <= !ce_n;
        base <= addr;
        cnt  <= '0;
      end else if (act && !adv_n) begin
        cnt <= cnt + 2'd1;
      end
      rd1_vld <= do_rd;
      oq_vld  <= rd1_vld;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (go && lane_we[i]) mem[cur][i*LW +: LW] <= din[i*LW +: LW];
    if (do_rd) rd1_q <= mem[cur];
    oq <= rd1_q;
  end

  assign dout_drv = !oe_n && oq_vld;
  assign dout     = dout_drv ? oq : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adsc_n,
  input logic               adsp_n,
  input logic               ce_n,
  input logic               adv_n,
  input logic               sleep,
  input logic               oe_n,
  input logic               dout_drv,
  input logic [9*LANES-1:0] dout,
  input logic               act,
  input logic [1:0]         cnt
);
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_drv);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drv |-> dout == '0);

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !adsc_n |=> (cnt == 2'd0) && (act == !$past(ce_n)));

  assert_adsp_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && ce_n) |=> act == $past(act));

  assert_adv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && adsc_n && (adsp_n || ce_n) && !adv_n) |=> cnt == 2'($past(cnt) + 2'd1));

  assert_adv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && (adsp_n || ce_n) && adv_n) |=> $stable(cnt));

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && ce_n) |-> ##3 !dout_drv);

  assert_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ##2 !dout_drv);
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk, .rst_n, .adsc_n, .adsp_n, .ce_n, .adv_n, .sleep, .oe_n,
  .dout_drv, .dout, .act, .cnt
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int TCK = 10;
  localparam int AW  = 6;
  localparam int NL  = 4;
  localparam int DW  = 9 * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adsc_n = 1'b1, adsp_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, sleep = 1'b0, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_drv;

  int total = 0, bad = 0, cyc_n = 0;
  bit mon_on = 1'b0;
  logic [DW-1:0] ref_m [1 << AW];
  logic [DW-1:0] q_d[$];
  int q_due[$];
  string q_tag[$];

  burst_sram #(.ADDR_W(AW), .LANES(NL)) u_dut (
    .clk, .rst_n, .addr, .adsc_n, .adsp_n, .ce_n, .adv_n, .mode,
    .gw_n, .bwe_n, .bw_n, .din, .sleep, .oe_n, .dout, .dout_drv
  );

  always #(TCK/2) clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  task automatic check(bit ok, string tag, logic [DW-1:0] act_v, logic [DW-1:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act_v, exp_v, cyc_n);
    end
  endtask

  task automatic push(logic [DW-1:0] d, int due, string tag);
    q_d.push_back(d); q_due.push_back(due); q_tag.push_back(tag);
  endtask

  always begin
    @(negedge clk); #1;
    if (rst_n && mon_on) begin
      while (q_due.size() > 0 && q_due[0] < cyc_n) begin
        check(1'b0, {q_tag[0], " R6 missed word"}, '0, q_d[0]);
        void'(q_d.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
      end
      if (q_due.size() > 0 && q_due[0] == cyc_n) begin
        if (oe_n)
          check(!dout_drv && dout == '0, "R10 output enable off", dout, '0);
        else
          check(dout_drv && dout == q_d[0], {q_tag[0], " R6 read word"}, dout, q_d[0]);
        void'(q_d.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
      end else begin
        check(!dout_drv, "R9 unexpected drive", {35'd0, dout_drv}, '0);
      end
    end
  end

  function automatic int baddr(int start, int c, bit md);
    int lo = start & 3;
    int o  = md ? (lo ^ c) : ((lo + c) & 3);
    return (start & ~3) | o;
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    return {4'(salt), 32'(a * 32'h9E37_79B9 + salt * 32'h0101_0101)};
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic idle();
    adsc_n = 1; adsp_n = 1; ce_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; sleep = 0;
  endtask

  task automatic wr_burst(int start, bit md, bit gw, bit bwe, logic [NL-1:0] bw,
                          bit slp, int salt, string tag);
    int c = 0;
    idle(); mode = md; addr = AW'(start); adsc_n = 0; ce_n = 0; step();
    for (int i = 0; i < 4; i++) begin
      int a;
      logic [DW-1:0] d;
      bit anyw = 0;
      idle(); mode = md;
      adsc_n = (i == 3) ? 1'b0 : 1'b1; ce_n = (i == 3);
      adv_n = (i == 3); gw_n = !gw; bwe_n = !bwe; bw_n = ~bw; sleep = slp;
      a = baddr(start, c, md); d = pat(a, salt); din = d;
      for (int l = 0; l < NL; l++)
        if (gw || (bwe && bw[l])) begin
          anyw = 1;
          if (!slp) ref_m[a][l*9 +: 9] = d[l*9 +: 9];
        end
      if (!anyw && !slp) push(ref_m[a], cyc_n + 2, tag);
      if (i < 3) c++;
      step();
    end
    idle();
  endtask

  task automatic rd_burst(int start, bit md, bit asp, logic [3:0] advm, bit poke,
                          bit slp, int oeoff, string tag);
    int c = 0;
    idle(); mode = md; addr = AW'(start);
    if (asp) adsp_n = 0; else adsc_n = 0;
    ce_n = 0; step();
    for (int i = 0; i < 4; i++) begin
      idle(); mode = md; ce_n = 0; adv_n = !advm[i]; sleep = slp;
      oe_n = (i == oeoff);
      if (poke && i == 1) begin adsp_n = 0; ce_n = 1; addr = AW'(start ^ 32); end
      if (i == 3) begin adsc_n = 0; ce_n = 1; end
      if (!slp) push(ref_m[baddr(start, c, md)], cyc_n + 2, tag);
      if (advm[i]) c = (c + 1) & 3;
      step();
    end
    idle();
    oe_n = (oeoff == 4);
    step();
    oe_n = 0;
  endtask

  initial begin
    #(TCK * 200000);
    check(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) step();
    check(!dout_drv && dout == '0, "R12 drivers off in reset", dout, '0);
    rst_n = 1;
    step();
    check(!dout_drv && dout == '0, "R12 drivers off after reset", dout, '0);
    mon_on = 1;
    for (int b = 0; b < 16; b++) wr_burst(b * 4, 0, 1, 0, '0, 0, 1, "init");
    rd_burst(5, 0, 0, 4'b1111, 0, 0, 9, "R1 R4 linear");
    rd_burst(5, 1, 0, 4'b1111, 0, 0, 9, "R5 interleaved");
    rd_burst(10, 0, 1, 4'b1111, 0, 0, 9, "R2 adsp load");
    wr_burst(21, 1, 1, 0, 4'b0000, 0, 2, "R8");
    rd_burst(21, 1, 0, 4'b1111, 0, 0, 9, "R8 global write");
    wr_burst(33, 0, 0, 1, 4'b0101, 0, 3, "R7");
    rd_burst(33, 0, 0, 4'b1111, 0, 0, 9, "R7 lane merge");
    wr_burst(40, 0, 0, 0, 4'b1111, 0, 5, "R7 no-lane write reads");
    rd_burst(40, 0, 0, 4'b1111, 0, 0, 9, "R7 array unchanged");
    rd_burst(48, 0, 0, 4'b0101, 0, 0, 9, "R3 stalled burst");
    rd_burst(50, 0, 1, 4'b1111, 1, 0, 9, "R2 ignored strobe");
    wr_burst(56, 0, 1, 0, 4'b0000, 1, 4, "R11");
    rd_burst(56, 0, 0, 4'b1111, 0, 0, 9, "R11 sleep blocked write");
    rd_burst(57, 1, 0, 4'b1111, 0, 1, 9, "R11 sleep blocked read");
    rd_burst(60, 1, 0, 4'b1111, 0, 0, 3, "R10");
    wr_burst(62, 0, 0, 1, 4'b1000, 0, 6, "R7");
    rd_burst(62, 1, 1, 4'b1111, 0, 0, 9, "R5 R7 lane three");
    repeat (6) step();
    check(q_due.size() == 0, "R6 all words delivered", DW'(q_due.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule